// File: doc/BRIEF.md
# Flash Program/Erase Status-Polling Sequencer

This block sits on the host side of a byte-wide parallel flash bus. It takes one request at a time and carries it through a complete automatic operation on the device. A request is a byte program (address and data), a whole-chip erase, or an erase of a set of blocks given as a bit mask. The block issues the command writes, reads the device's status repeatedly until the operation settles, and reports either a one-cycle `done` or a one-cycle `fail`.

Completion is judged from two status bits of each read byte. Bit 6 flips on every read while the device is working. Bit 7 holds a polling value: during a program it is the inverse of the written bit 7, and during an erase it is 0. An operation counts as finished only when bit 6 has the same value on two consecutive reads and bit 7 shows the final value. A program is additionally verified against the whole written byte.

If the device never settles within a parameterized number of reads, or a program verifies wrong, the block writes the reset byte twice and reports a failure. Bus strobe width, idle gap and the wait after block loading are all parameters, counted in clock cycles.

Top module: `flash_op_seq`

## Requirements
- R1: A program request (`reqOp` = 0) produces the write 0x40 at address 0, then the write of `reqData` at `reqAddr`.
- R2: A chip-erase request (`reqOp` = 1) produces two writes of 0x30, both at address 0.
- R3: A block-erase request (`reqOp` = 2) produces the write 0x20 at address 0, then one write of 0xD0 for each set bit of `reqBlockMask`, in ascending bit order, at address `index << (ADDR_W - log2(NUM_BLK))`.
- R4: After the last 0xD0 write of a block erase, the bus stays idle for at least `SETTLE_CYC` cycles before the first status read.
- R5: Status reads target the poll address: `reqAddr` for a program, 0 for a chip erase, and the base of the lowest selected block for a block erase. For program and chip erase the first read follows the second command write with no extra wait.
- R6: A program finishes when a read has bit 6 equal to the previous read's bit 6 and bits 7:6 equal to those of `reqData`. If that read equals the whole `reqData` byte, `done` is reported. Otherwise the failure path of R8 is taken.
- R7: An erase finishes with `done` when a read has bit 6 equal to the previous read's bit 6 and bit 7 equal to 1.
- R8: If `MAX_POLLS` reads pass without completion, or a program verify fails, the block writes 0xFF twice at address 0 and then reports `fail`.
- R9: `busy` is high from the cycle after a request is accepted until the report. `done` or `fail` is high for exactly one cycle, the first cycle with `busy` low, which is `GAP_CYC + 1` cycles after the final strobe falls.
- R10: A request presented while `busy` is high is ignored and does not disturb the running operation.
- R11: A request with `reqOp` = 3, or a block erase with an all-zero mask, is ignored.
- R12: Each access holds exactly one strobe (`busWe` or `busRe`) high for `PULSE_CYC` cycles, with address and write data stable throughout. At least `GAP_CYC` idle cycles separate accesses. Read data is sampled in the last strobe cycle. Strobes occur only while `busy` is high.
- R13: After reset, `busy`, `done`, `fail`, `busWe` and `busRe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqOp | input | 2 | 0 program, 1 chip erase, 2 block erase, 3 reserved |
| reqAddr | input | ADDR_W | Program address |
| reqData | input | 8 | Program data |
| reqBlockMask | input | NUM_BLK | Blocks to erase, bit i selects block i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success report |
| fail | output | 1 | One-cycle failure report |
| busAddr | output | ADDR_W | Flash bus address |
| busWrData | output | 8 | Flash bus write data |
| busWe | output | 1 | Write strobe, active high |
| busRe | output | 1 | Read strobe, active high |
| busRdData | input | 8 | Flash bus read data |

## Verification
The embedded assertions assume that `busRdData` is stable by the last cycle of each read strobe and that reset is asserted long enough to clear every register. They also assume that request fields are meaningful only in the cycle `reqValid` is high. The bench's responder sets the read byte half a cycle after each read strobe rises and holds it for the whole strobe. Requests are driven away from the clock edge, and the illegal and mid-operation requests are the only ones that reach the block outside the idle state.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_BLK  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    W_SETUP,
    W_SECOND,
    W_BLKLOAD,
    W_RESET
  } wsel_e;

  typedef enum logic [1:0] {
    A_ZERO,
    A_POLL,
    A_BLOCK
  } asel_e;

  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_CHIP        = 8'h30;
  localparam logic [7:0] CMD_BLK_SETUP   = 8'h20;
  localparam logic [7:0] CMD_BLK_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_RESET       = 8'hFF;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;        // capture request fields
    logic  go;          // start a bus access
    logic  rd;          // access is a read
    wsel_e wsel;        // write byte select
    asel_e asel;        // address select
    logic  pollClr;     // restart poll history
    logic  blkAdvance;  // drop lowest pending block
    logic  waitStart;   // arm settle counter
  } ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic accDone;
    logic pollOk;
    logic verifyBad;
    logic pollLimit;
    logic moreBlk;
    logic waitDone;
    logic reqLegal;
    logic isBlk;
  } sts_t;

endpackage

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int NUM_BLK    = 8,
  parameter int PULSE_CYC  = 4,
  parameter int GAP_CYC    = 2,
  parameter int SETTLE_CYC = 50000,
  parameter int MAX_POLLS  = 100000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [7:0]          reqData,
  input  logic [NUM_BLK-1:0]  reqBlockMask,
  input  logic [7:0]          busRdData,
  input  ctl_t                ctl,
  output sts_t                sts,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [7:0]          busWrData,
  output logic                busWe,
  output logic                busRe
);

  localparam int BLK_W = $clog2(NUM_BLK);
  localparam int OFS_W = ADDR_W - BLK_W;
  localparam int TMAX  = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int WW    = $clog2(SETTLE_CYC + 1);
  localparam int PW    = $clog2(MAX_POLLS + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_GAP} phase_e;

  function automatic logic [BLK_W-1:0] lowIdx(input logic [NUM_BLK-1:0] m);
    lowIdx = '0;
    for (int i = NUM_BLK - 1; i >= 0; i--) begin
      if (m[i]) lowIdx = BLK_W'(i);
    end
  endfunction

  function automatic logic [ADDR_W-1:0] blkBase(input logic [BLK_W-1:0] idx);
    blkBase = {idx, {OFS_W{1'b0}}};
  endfunction

  op_e                opReg;
  logic [7:0]         dataReg;
  logic [NUM_BLK-1:0] maskReg;
  logic [ADDR_W-1:0]  pollAddr;
  phase_e             phase;
  logic [TW-1:0]      tCnt;
  logic               isRd;
  logic [7:0]         rdReg;
  logic               prevB6;
  logic               havePrev;
  logic [PW-1:0]      pollCnt;
  logic [WW-1:0]      waitCnt;

  logic               accDone;
  logic               engFree;
  logic [7:0]         selData;
  logic [ADDR_W-1:0]  selAddr;
  logic               critHit;
  logic               stableHit;
  logic [NUM_BLK-1:0] maskRest;

  // ---------------- request capture ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opReg    <= OP_PROG;
      dataReg  <= '0;
      maskReg  <= '0;
      pollAddr <= '0;
    end else if (ctl.load) begin
      opReg    <= op_e'(reqOp);
      dataReg  <= reqData;
      maskReg  <= reqBlockMask;
      case (op_e'(reqOp))
        OP_PROG: pollAddr <= reqAddr;
        OP_BLK:  pollAddr <= blkBase(lowIdx(reqBlockMask));
        default: pollAddr <= '0;
      endcase
    end else if (ctl.blkAdvance) begin
      maskReg <= maskRest;
    end
  end

  assign maskRest = maskReg & (maskReg - NUM_BLK'(1));

  // ---------------- write byte and address select ----------------
  always_comb begin
    selData = 8'h00;
    if (!ctl.rd) begin
      case (ctl.wsel)
        W_SETUP: begin
          case (opReg)
            OP_PROG: selData = CMD_PROG_SETUP;
            OP_BLK:  selData = CMD_BLK_SETUP;
            default: selData = CMD_CHIP;
          endcase
        end
        W_SECOND:  selData = (opReg == OP_PROG) ? dataReg : CMD_CHIP;
        W_BLKLOAD: selData = CMD_BLK_CONFIRM;
        default:   selData = CMD_RESET;
      endcase
    end
  end

  always_comb begin
    case (ctl.asel)
      A_POLL:  selAddr = pollAddr;
      A_BLOCK: selAddr = blkBase(lowIdx(maskReg));
      default: selAddr = '0;
    endcase
  end

  // ---------------- bus access engine ----------------
  assign accDone = (phase == PH_GAP) && (tCnt == TW'(GAP_CYC - 1));
  assign engFree = (phase == PH_IDLE) || accDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      tCnt      <= '0;
      isRd      <= 1'b0;
      busAddr   <= '0;
      busWrData <= '0;
      rdReg     <= '0;
    end else if (ctl.go) begin
      phase     <= PH_STROBE;
      tCnt      <= '0;
      isRd      <= ctl.rd;
      busAddr   <= selAddr;
      busWrData <= selData;
    end else begin
      case (phase)
        PH_STROBE: begin
          if (tCnt == TW'(PULSE_CYC - 1)) begin
            phase <= PH_GAP;
            tCnt  <= '0;
            if (isRd) rdReg <= busRdData;
          end else begin
            tCnt <= tCnt + TW'(1);
          end
        end
        PH_GAP: begin
          if (accDone) phase <= PH_IDLE;
          else         tCnt  <= tCnt + TW'(1);
        end
        default: ;
      endcase
    end
  end

  assign busWe = (phase == PH_STROBE) && !isRd;
  assign busRe = (phase == PH_STROBE) && isRd;

  // ---------------- status history and poll count ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevB6   <= 1'b0;
      havePrev <= 1'b0;
      pollCnt  <= '0;
    end else if (ctl.pollClr) begin
      havePrev <= 1'b0;
      pollCnt  <= '0;
    end else if (accDone && isRd) begin
      prevB6   <= rdReg[6];
      havePrev <= 1'b1;
      pollCnt  <= pollCnt + PW'(1);
    end
  end

  assign critHit   = (opReg == OP_PROG) ? (rdReg[7:6] == dataReg[7:6]) : rdReg[7];
  assign stableHit = accDone && isRd && havePrev && (rdReg[6] == prevB6) && critHit;

  // ---------------- settle counter ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              waitCnt <= '0;
    else if (ctl.waitStart)  waitCnt <= WW'(SETTLE_CYC - 1);
    else if (waitCnt != '0)  waitCnt <= waitCnt - WW'(1);
  end

  always_comb begin
    sts           = '0;
    sts.accDone   = accDone;
    sts.pollOk    = stableHit && ((opReg != OP_PROG) || (rdReg == dataReg));
    sts.verifyBad = stableHit && (opReg == OP_PROG) && (rdReg != dataReg);
    sts.pollLimit = (pollCnt == PW'(MAX_POLLS - 1));
    sts.moreBlk   = (maskRest != '0);
    sts.waitDone  = (waitCnt == '0);
    sts.reqLegal  = (op_e'(reqOp) != OP_RSVD) &&
                    !((op_e'(reqOp) == OP_BLK) && (reqBlockMask == '0));
    sts.isBlk     = (opReg == OP_BLK);
  end

  // ---------------- assertions ----------------
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWe && busRe));

  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((busWe || busRe) && $past(busWe || busRe)) |-> ($stable(busAddr) && $stable(busWrData)));

  a_r12_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.go |-> engFree);

  a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pollCnt <= PW'(MAX_POLLS));

  a_r3_advance_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.blkAdvance |-> (maskReg != '0));

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reqValid,
  input  sts_t sts,
  output ctl_t ctl,
  output logic busy,
  output logic done,
  output logic fail
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CMD1, S_BLKNEXT, S_BLK,
    S_CMD2, S_SETTLE, S_POLL, S_RST1, S_RST2
  } state_e;

  state_e st, nxt;
  logic   setDone, setFail;

  always_comb begin
    ctl     = '0;
    nxt     = st;
    setDone = 1'b0;
    setFail = 1'b0;
    case (st)
      S_IDLE: begin
        if (reqValid && sts.reqLegal) begin
          ctl.load = 1'b1;
          nxt      = S_START;
        end
      end
      S_START: begin
        ctl.go   = 1'b1;
        ctl.wsel = W_SETUP;
        ctl.asel = A_ZERO;
        nxt      = S_CMD1;
      end
      S_CMD1: begin
        if (sts.accDone) begin
          if (sts.isBlk) begin
            nxt = S_BLKNEXT;
          end else begin
            ctl.go   = 1'b1;
            ctl.wsel = W_SECOND;
            ctl.asel = A_POLL;
            nxt      = S_CMD2;
          end
        end
      end
      S_BLKNEXT: begin
        ctl.go   = 1'b1;
        ctl.wsel = W_BLKLOAD;
        ctl.asel = A_BLOCK;
        nxt      = S_BLK;
      end
      S_BLK: begin
        if (sts.accDone) begin
          ctl.blkAdvance = 1'b1;
          if (sts.moreBlk) begin
            nxt = S_BLKNEXT;
          end else begin
            ctl.waitStart = 1'b1;
            nxt           = S_SETTLE;
          end
        end
      end
      S_CMD2: begin
        if (sts.accDone) begin
          ctl.go      = 1'b1;
          ctl.rd      = 1'b1;
          ctl.asel    = A_POLL;
          ctl.pollClr = 1'b1;
          nxt         = S_POLL;
        end
      end
      S_SETTLE: begin
        if (sts.waitDone) begin
          ctl.go      = 1'b1;
          ctl.rd      = 1'b1;
          ctl.asel    = A_POLL;
          ctl.pollClr = 1'b1;
          nxt         = S_POLL;
        end
      end
      S_POLL: begin
        if (sts.accDone) begin
          if (sts.pollOk) begin
            setDone = 1'b1;
            nxt     = S_IDLE;
          end else if (sts.verifyBad || sts.pollLimit) begin
            ctl.go   = 1'b1;
            ctl.wsel = W_RESET;
            ctl.asel = A_ZERO;
            nxt      = S_RST1;
          end else begin
            ctl.go   = 1'b1;
            ctl.rd   = 1'b1;
            ctl.asel = A_POLL;
          end
        end
      end
      S_RST1: begin
        if (sts.accDone) begin
          ctl.go   = 1'b1;
          ctl.wsel = W_RESET;
          ctl.asel = A_ZERO;
          nxt      = S_RST2;
        end
      end
      S_RST2: begin
        if (sts.accDone) begin
          setFail = 1'b1;
          nxt     = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      st   <= nxt;
      done <= setDone;
      fail <= setFail;
    end
  end

  assign busy = (st != S_IDLE);

  // ---------------- assertions ----------------
  a_r9_report_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);

  a_r9_report_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fail));

  a_r9_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  a_r10_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |-> !busy);

  a_r8_reset_after_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL && sts.accDone && !sts.pollOk && (sts.pollLimit || sts.verifyBad))
      |=> (st == S_RST1));

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int NUM_BLK    = 8,
  parameter int PULSE_CYC  = 4,
  parameter int GAP_CYC    = 2,
  parameter int SETTLE_CYC = 50000,
  parameter int MAX_POLLS  = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [7:0]         reqData,
  input  logic [NUM_BLK-1:0] reqBlockMask,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [7:0]         busWrData,
  output logic               busWe,
  output logic               busRe,
  input  logic [7:0]         busRdData
);

  ctl_t ctl;
  sts_t sts;

  fps_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .sts      (sts),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
  );

  fps_datapath #(
    .ADDR_W     (ADDR_W),
    .NUM_BLK    (NUM_BLK),
    .PULSE_CYC  (PULSE_CYC),
    .GAP_CYC    (GAP_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .MAX_POLLS  (MAX_POLLS)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqOp        (reqOp),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .reqBlockMask (reqBlockMask),
    .busRdData    (busRdData),
    .ctl          (ctl),
    .sts          (sts),
    .busAddr      (busAddr),
    .busWrData    (busWrData),
    .busWe        (busWe),
    .busRe        (busRe)
  );

endmodule

// File: tb/flash_op_seq_bench.sv
`timescale 1ns/1ps
module flash_op_seq_bench;

  localparam int AW   = 17;
  localparam int NB   = 8;
  localparam int PUL  = 3;
  localparam int GAP  = 2;
  localparam int SET  = 40;
  localparam int MAXP = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic [NB-1:0] reqBlockMask = '0;
  logic          busy, done, fail;
  logic [AW-1:0] busAddr;
  logic [7:0]    busWrData;
  logic          busWe, busRe;
  logic [7:0]    busRdData = '0;

  always #2 clk = ~clk;  // 250 MHz

  flash_op_seq #(
    .ADDR_W(AW), .NUM_BLK(NB), .PULSE_CYC(PUL), .GAP_CYC(GAP),
    .SETTLE_CYC(SET), .MAX_POLLS(MAXP)
  ) u_flash_op_seq (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqBlockMask(reqBlockMask),
    .busy(busy), .done(done), .fail(fail), .busAddr(busAddr),
    .busWrData(busWrData), .busWe(busWe), .busRe(busRe), .busRdData(busRdData)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- scenario and reference model ----------------
  typedef struct { bit rd; logic [AW-1:0] a; logic [7:0] d; } tr_t;
  tr_t expQ[$];

  int         scOp, scBusy, scMode;   // mode 0 ok, 1 stuck, 2 bit7 never final, 3 low bit wrong
  bit         scTog;
  logic [7:0] scData;
  int         respIdx;

  function automatic logic [7:0] rdVal(input int i);
    logic [7:0] v;
    if (scMode == 1 || i < scBusy) begin
      v    = 8'h15 ^ 8'(i);
      v[6] = ((i % 2) == 1) ^ scTog;
      v[7] = (scOp == 0) ? ~scData[7] : 1'b0;
    end else if (scMode == 2) begin
      v    = scData;
      v[7] = ~scData[7];
    end else if (scMode == 3) begin
      v = scData ^ 8'h01;
    end else begin
      v = (scOp == 0) ? scData : 8'hFF;
    end
    return v;
  endfunction

  function automatic logic [AW-1:0] blkAddr(input int i);
    return AW'(i) << (AW - 3);
  endfunction

  bit expOk;

  task automatic buildExpect(input int op, input logic [AW-1:0] a,
                             input logic [7:0] d, input logic [NB-1:0] m);
    logic [AW-1:0] pa;
    logic [7:0] v, pv;
    int nRd;
    bit fin;
    expQ.delete();
    if (op == 0) begin
      expQ.push_back('{0, '0, 8'h40});
      expQ.push_back('{0, a, d});
      pa = a;
    end else if (op == 1) begin
      expQ.push_back('{0, '0, 8'h30});
      expQ.push_back('{0, '0, 8'h30});
      pa = '0;
    end else begin
      expQ.push_back('{0, '0, 8'h20});
      pa = '0;
      for (int i = NB - 1; i >= 0; i--) if (m[i]) pa = blkAddr(i);
      for (int i = 0; i < NB; i++) if (m[i]) expQ.push_back('{0, blkAddr(i), 8'hD0});
    end
    nRd = MAXP; fin = 0; expOk = 0; pv = '0;
    for (int i = 0; i < MAXP && !fin; i++) begin
      v = rdVal(i);
      if (i > 0 && v[6] == pv[6] &&
          ((op == 0) ? (v[7:6] == d[7:6]) : v[7])) begin
        fin = 1; nRd = i + 1;
        expOk = (op != 0) || (v == d);
      end
      pv = v;
    end
    for (int i = 0; i < nRd; i++) expQ.push_back('{1, pa, 8'h00});
    if (!expOk) begin
      expQ.push_back('{0, '0, 8'hFF});
      expQ.push_back('{0, '0, 8'hFF});
    end
  endtask

  // ---------------- per-clock bus monitor and responder ----------------
  int  trErr, tmErr, hiCnt, loCnt, endLo, settleLo, strobeRises;
  bit  prevStb, lastBlk, doneSeen, failSeen, settleChk;

  always @(negedge clk) begin
    bit stb;
    tr_t t;
    if (!rst_n) begin
      prevStb = 0; hiCnt = 0; loCnt = 100;
    end else begin
      stb = busWe | busRe;
      if (stb && !prevStb) begin
        strobeRises++;
        if (loCnt < GAP) tmErr++;
        if (busRe && lastBlk) begin settleChk = 1; settleLo = loCnt; end
        if (expQ.size() == 0) begin
          trErr++;
          $display("unexpected access addr %h data %h re %0d", busAddr, busWrData, busRe);
        end else begin
          t = expQ.pop_front();
          if (t.rd != busRe || t.a != busAddr || (!t.rd && t.d != busWrData)) begin
            trErr++;
            $display("trace mismatch: got re %0d addr %h data %h, want re %0d addr %h data %h",
                     busRe, busAddr, busWrData, t.rd, t.a, t.d);
          end
        end
        lastBlk = busWe && (busWrData == 8'hD0);
        if (busRe) begin busRdData = rdVal(respIdx); respIdx++; end
        hiCnt = 1;
      end else if (stb) begin
        hiCnt++;
      end
      if (!stb && prevStb) begin
        if (hiCnt != PUL) tmErr++;
        loCnt = 0;
      end
      if (!stb) loCnt++;
      if (stb && !busy) tmErr++;
      if (done) begin doneSeen = 1; endLo = loCnt; end
      if (fail) begin failSeen = 1; endLo = loCnt; end
      prevStb = stb;
    end
  end

  // ---------------- operation runner ----------------
  task automatic runOp(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic [NB-1:0] m, input int nBusy, input int mode,
                       input bit tog, input bit inject, input string trTag,
                       input string endTag);
    scOp = op; scData = d; scBusy = nBusy; scMode = mode; scTog = tog;
    buildExpect(op, a, d, m);
    respIdx = 0; trErr = 0; tmErr = 0; doneSeen = 0; failSeen = 0;
    settleChk = 0; lastBlk = 0;
    @(posedge clk); #1;
    reqValid = 1; reqOp = 2'(op); reqAddr = a; reqData = d; reqBlockMask = m;
    @(posedge clk); #1;
    reqValid = 0; reqOp = 2'd3; reqAddr = '1; reqData = 8'hA5; reqBlockMask = '1;
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    for (int c = 0; c < 4000 && !(doneSeen || failSeen); c++) begin
      @(posedge clk); #1;
      if (inject && c == 8) begin reqValid = 1; reqOp = 2'd1; end
      else reqValid = 0;
    end
    reqValid = 0;
    check(doneSeen == expOk && failSeen == !expOk, endTag, "verdict done",
          int'(doneSeen), int'(expOk));
    check(trErr == 0 && expQ.size() == 0, trTag, "bus trace errors/left",
          trErr + expQ.size(), 0);
    check(tmErr == 0, "R12", "access timing errors", tmErr, 0);
    check(endLo == GAP + 1, "R9", "report delay after last strobe", endLo, GAP + 1);
    @(negedge clk);
    check(!done && !fail && !busy, "R9", "report is one cycle",
          int'(done) + int'(fail) + int'(busy), 0);
  endtask

  task automatic idleProbe(input int op, input logic [NB-1:0] m, input string tag);
    int rises;
    rises = strobeRises;
    @(posedge clk); #1;
    reqValid = 1; reqOp = 2'(op); reqBlockMask = m;
    @(posedge clk); #1;
    reqValid = 0;
    repeat (20) @(posedge clk);
    #1;
    check(!busy && strobeRises == rises, tag, "request ignored (busy+accesses)",
          int'(busy) + strobeRises - rises, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !fail && !busWe && !busRe, "R13", "reset outputs",
          int'(busy) + int'(done) + int'(fail) + int'(busWe) + int'(busRe), 0);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // program, settles on the first final read or the one after
    runOp(0, 17'h0ABCD, 8'h5A, '0, 3, 0, 1'b0, 1'b0, "R1,R5", "R6");
    runOp(0, 17'h1FFFF, 8'hC3, '0, 4, 0, 1'b1, 1'b0, "R1,R5", "R6");
    // program verify mismatch in low bit -> reset writes and fail
    runOp(0, 17'h00010, 8'h81, '0, 2, 3, 1'b0, 1'b0, "R6,R8", "R6");
    // program where bit 7 never reaches its final value
    runOp(0, 17'h00123, 8'h3C, '0, 2, 2, 1'b0, 1'b0, "R8", "R8");
    // chip erase
    runOp(1, '0, 8'h00, '0, 5, 0, 1'b0, 1'b0, "R2,R5", "R7");
    // chip erase that never finishes
    runOp(1, '0, 8'h00, '0, 0, 1, 1'b1, 1'b0, "R2,R8", "R8");
    // block erase, several blocks
    runOp(2, '0, 8'h00, 8'b1001_0100, 2, 0, 1'b0, 1'b0, "R3,R5", "R7");
    check(settleChk && settleLo >= SET, "R4", "idle cycles before first read", settleLo, SET);
    // block erase, top block only
    runOp(2, '0, 8'h00, 8'b1000_0000, 1, 0, 1'b1, 1'b0, "R3,R5", "R7");
    check(settleChk && settleLo >= SET, "R4", "idle cycles before first read", settleLo, SET);
    // program with a chip-erase request pushed in while busy
    runOp(0, 17'h04444, 8'hE7, '0, 3, 0, 1'b0, 1'b1, "R10", "R10");
    repeat (20) @(posedge clk);
    #1;
    check(!busy, "R10", "no operation started from mid-run request", int'(busy), 0);
    // illegal requests
    idleProbe(3, 8'hFF, "R11");
    idleProbe(2, 8'h00, "R11");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule